// File: doc/BRIEF.md
# Baseband Bit Serializer with NRZ and Manchester Coding

This block sits between a host controller and a two-level FSK modem. In the transmit direction it drives a bit clock toward the host and samples one host bit per clock period on a shared data pin. It emits a symbol stream to the modulator that begins with a programmable run of preamble bytes and start-of-frame bytes. Symbols are plain NRZ levels or Manchester pairs. In the receive direction it samples the symbol stream from the demodulator, decodes one bit per period, and drives that bit back to the host on the same data pin, paced by the same bit clock.

All timing comes from a single master clock. A base divider gives the length of the fastest over-the-air symbol: 4000 master cycles for 4800 bit/s from 19.2 MHz. A two-bit rate code stretches this by 1, 2 or 4. In Manchester mode a host bit spans two symbols, so the host rate is half the air rate. A session starts when `run` is raised. The direction, coding, rate, bit order, field lengths and patterns are captured at that moment.

Top module: `bbs_serdes_top`

## Requirements
- R1: After a synchronous active-low reset, `dclk`, `sym_out`, `dio_oe`, `dio_out` and `rx_code_err` are all low.
- R2: The symbol length S is BASE_DIV×4, BASE_DIV×2 or BASE_DIV master cycles for rate codes 0, 1 and 2 respectively, and code 3 acts as code 2. The host bit period H is S in NRZ and 2S in Manchester. `dclk` is low for the first H/2 cycles of every period and high for the rest.
- R3: A transmit session starts with one lead-in period in which `sym_out` stays low. Next come the preamble bytes (`cfg_pre_len` copies of `cfg_pre_pat`), then the start-of-frame bytes (`cfg_sfd_len` copies of `cfg_sfd_pat`), then host data. A zero length skips its field. A preamble length above 16 is treated as 16, and a start-of-frame length above 18 is treated as 18.
- R4: Header bytes are sent bit 7 first when `cfg_msb_first` is 1, and bit 0 first when it is 0.
- R5: In transmit, `dio_in` is captured on the master-clock edge that ends the first `dclk`-high cycle of a period. The captured bit is sent during the following period. The first host bit is captured in the last header period, or in the lead-in period when both lengths are zero.
- R6: NRZ sends the bit as the level for the whole period. Manchester sends 1 as high then low, and 0 as low then high, switching at the middle of the period.
- R7: In receive, `sym_in` is sampled in the middle of each symbol: at cycle S/2, and in Manchester also at cycle 3S/2 of the period. The decoded bit (the first sample) is driven on `dio_out` for the whole next period.
- R8: In Manchester receive, two equal half-samples raise `rx_code_err` for exactly the first cycle of the next period. It never rises in NRZ.
- R9: `dio_oe` is high exactly while a receive session is active. `dio_out` is low in the first period after the pin turns to an output, and whenever it is not driven.
- R10: Lowering `run` takes effect only at the edge that closes the current host bit period. While idle, `dclk`, `sym_out` and `dio_oe` are low.
- R11: Changes to any `cfg_*` input during an active session have no effect on that session's timing, direction, coding or header content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Session request; sampled when idle and at period ends |
| cfg_dir_tx | input | 1 | 1 = transmit session, 0 = receive session |
| cfg_manch | input | 1 | 1 = Manchester coding, 0 = NRZ |
| cfg_rate | input | 2 | Rate code: 0 slowest, 2 fastest, 3 same as 2 |
| cfg_msb_first | input | 1 | Header byte bit order |
| cfg_pre_len | input | LEN_W (5) | Preamble byte count |
| cfg_sfd_len | input | LEN_W (5) | Start-of-frame byte count |
| cfg_pre_pat | input | 8 | Preamble byte pattern |
| cfg_sfd_pat | input | 8 | Start-of-frame byte pattern |
| dio_in | input | 1 | Data pin input value (host to block) |
| dio_out | output | 1 | Data pin output value (block to host) |
| dio_oe | output | 1 | Data pin output enable |
| dclk | output | 1 | Host bit clock |
| sym_out | output | 1 | Symbol stream to the modulator |
| sym_in | input | 1 | Symbol stream from the demodulator |
| rx_code_err | output | 1 | One-cycle Manchester coding error flag |

## Verification
Every result is tied to a period index counted from the edge that starts the session. A transmitted header or data bit shows on `sym_out` one period after its slot is reached. A host bit captured in period j appears in period j+1. A decoded receive bit appears on `dio_out` in the period after its symbols, and its error flag appears in the first cycle of that period. The bench walks each period cycle by cycle from that starting edge. It samples on the falling clock edge at fixed offsets (cycle 0, cycle 1 and cycle H/2+1 of a period), so each expected value is compared in the cycle it is due. Stops are checked at the cycle right after the closing edge.

// File: rtl/bbs_pkg.sv
// Shared types and helpers for the baseband serializer.
// Assumes byte patterns are 8 bits wide.
package bbs_pkg;

    // Transmit frame sections, in the order they are sent
    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,
        PH_PRE  = 2'd1,
        PH_SFD  = 2'd2,
        PH_DATA = 2'd3
    } tx_phase_e;

    // Picks bit number idx of a header byte, honouring the bit order
    function automatic logic pick_bit(input logic [7:0] pat,
                                      input logic [2:0] idx,
                                      input logic       msb_first);
        return msb_first ? pat[3'd7 - idx] : pat[idx];
    endfunction

endpackage

// File: rtl/bbs_bit_timer.sv
// Bit-period timer shared by both directions.
// Counts master cycles inside one host bit period and marks the sample
// points. Rate and coding are captured when a session starts.
// Assumes BASE_DIV is even and at least 4.
module bbs_bit_timer #(
    parameter int BASE_DIV = 4000,
    parameter int CW       = $clog2(8 * BASE_DIV + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       manch_in,
    input  logic [1:0] rate_in,
    output logic       active,
    output logic       start,
    output logic       manch,
    output logic       bit_end,
    output logic       samp_mid,
    output logic       samp_a,
    output logic       samp_b,
    output logic       second_half
);
    localparam logic [CW-1:0] SYM_FAST = CW'(BASE_DIV);
    localparam logic [CW-1:0] SYM_MID  = CW'(2 * BASE_DIV);
    localparam logic [CW-1:0] SYM_SLOW = CW'(4 * BASE_DIV);

    logic [1:0]    rate_l;
    logic [CW-1:0] cnt;
    logic [CW-1:0] sym_len;
    logic [CW-1:0] per_len;
    logic [CW-1:0] half_len;

    // Symbol length selected by the captured rate code
    always_comb begin
        case (rate_l)
            2'd0:    sym_len = SYM_SLOW;
            2'd1:    sym_len = SYM_MID;
            default: sym_len = SYM_FAST;
        endcase
        per_len  = manch ? (sym_len << 1) : sym_len;
        half_len = per_len >> 1;
    end

    assign start       = !active && run;
    assign bit_end     = active && (cnt == per_len - 1'b1);
    assign samp_mid    = active && (cnt == half_len);
    assign samp_a      = active && (cnt == (sym_len >> 1));
    assign samp_b      = active && manch && (cnt == sym_len + (sym_len >> 1));
    assign second_half = active && (cnt >= half_len);

    // Session control and cycle counter within the host bit period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            rate_l <= 2'd0;
            manch  <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            rate_l <= rate_in;
            manch  <= manch_in;
        end else if (active) begin
            if (bit_end) begin
                cnt    <= '0;
                active <= run;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < per_len));

    // R10
    stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && !run) |=> !active);

    // R10
    no_early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_end) |=> active);

endmodule

// File: rtl/bbs_tx_engine.sv
// Transmit sequencer and symbol encoder.
// Walks lead-in, preamble, start-of-frame and data sections, one bit per
// host period, and encodes the current bit as NRZ or Manchester.
// Assumes header lengths are already clamped and given in bits.
module bbs_tx_engine
    import bbs_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tx_on,
    input  logic          bit_end,
    input  logic          samp_mid,
    input  logic          second_half,
    input  logic          manch,
    input  logic          msb_first,
    input  logic [FW-1:0] pre_bits,
    input  logic [FW-1:0] sfd_bits,
    input  logic [7:0]    pre_pat,
    input  logic [7:0]    sfd_pat,
    input  logic          dio_in,
    output logic          sym_out
);
    tx_phase_e     phase;
    tx_phase_e     nxt_phase;
    logic [FW-1:0] fbit;
    logic [FW-1:0] fbit_inc;
    logic [FW-1:0] nxt_fbit;
    logic          nxt_bit;
    logic          cur_bit;
    logic          host_bit;

    assign fbit_inc = fbit + 1'b1;

    // Next section, position and bit at the close of the current period
    always_comb begin
        nxt_phase = phase;
        nxt_fbit  = fbit_inc;
        unique case (phase)
            PH_LEAD: begin
                nxt_fbit = '0;
                if (pre_bits != '0)      nxt_phase = PH_PRE;
                else if (sfd_bits != '0) nxt_phase = PH_SFD;
                else                     nxt_phase = PH_DATA;
            end
            PH_PRE: begin
                if (fbit_inc >= pre_bits) begin
                    nxt_fbit  = '0;
                    nxt_phase = (sfd_bits != '0) ? PH_SFD : PH_DATA;
                end
            end
            PH_SFD: begin
                if (fbit_inc >= sfd_bits) begin
                    nxt_fbit  = '0;
                    nxt_phase = PH_DATA;
                end
            end
            PH_DATA: nxt_fbit = '0;
        endcase
        case (nxt_phase)
            PH_PRE:  nxt_bit = pick_bit(pre_pat, nxt_fbit[2:0], msb_first);
            PH_SFD:  nxt_bit = pick_bit(sfd_pat, nxt_fbit[2:0], msb_first);
            PH_DATA: nxt_bit = host_bit;
            default: nxt_bit = 1'b0;
        endcase
    end

    // Section sequencer, advancing once per host bit period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_LEAD;
            fbit    <= '0;
            cur_bit <= 1'b0;
        end else if (start) begin
            phase   <= PH_LEAD;
            fbit    <= '0;
            cur_bit <= 1'b0;
        end else if (tx_on && bit_end) begin
            phase   <= nxt_phase;
            fbit    <= nxt_fbit;
            cur_bit <= nxt_bit;
        end
    end

    // Host bit capture while the bit clock is high
    always_ff @(posedge clk) begin
        if (!rst_n)               host_bit <= 1'b0;
        else if (tx_on && samp_mid) host_bit <= dio_in;
    end

    assign sym_out = tx_on && (phase != PH_LEAD) && (cur_bit ^ (manch && second_half));

    // R6
    manch_mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_on && manch && (phase != PH_LEAD) && $rose(second_half))
            |-> (sym_out != $past(sym_out)));

    // R3
    field_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_on && bit_end && (phase == PH_SFD)) |=> (phase != PH_PRE));

endmodule

// File: rtl/bbs_rx_engine.sv
// Receive decoder.
// Samples the modem symbol stream mid-symbol, decodes one bit per host
// period and flags Manchester pairs whose halves agree.
// Assumes the incoming symbols are aligned to the session start.
module bbs_rx_engine (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rx_on,
    input  logic bit_end,
    input  logic samp_a,
    input  logic samp_b,
    input  logic manch,
    input  logic sym_in,
    output logic dio_out,
    output logic code_err
);
    logic first_s;
    logic second_s;
    logic bit_q;
    logic err_q;

    // Mid-symbol sampling of each half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_s  <= 1'b0;
            second_s <= 1'b0;
        end else if (rx_on) begin
            if (samp_a) first_s  <= sym_in;
            if (samp_b) second_s <= sym_in;
        end
    end

    // Decoded bit and error flag, updated at the close of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            err_q <= 1'b0;
        end else if (start) begin
            bit_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= rx_on && bit_end && manch && (first_s == second_s);
            if (rx_on && bit_end) bit_q <= first_s;
        end
    end

    assign dio_out  = rx_on && bit_q;
    assign code_err = rx_on && err_q;

    // R8
    err_needs_manch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> manch);

    // R8
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> !code_err);

    // R7
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_on && !bit_end && !start) |=> $stable(bit_q));

endmodule

// File: rtl/bbs_serdes_top.sv
// Baseband serializer top.
// Captures the configuration at session start, shares one bit timer
// between the transmit encoder and receive decoder, and drives the
// host-side data pin and bit clock.
// Assumes run and cfg_* are synchronous to clk.
module bbs_serdes_top #(
    parameter int BASE_DIV = 4000,
    parameter int PRE_MAX  = 16,
    parameter int SFD_MAX  = 18,
    parameter int LEN_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_dir_tx,
    input  logic             cfg_manch,
    input  logic [1:0]       cfg_rate,
    input  logic             cfg_msb_first,
    input  logic [LEN_W-1:0] cfg_pre_len,
    input  logic [LEN_W-1:0] cfg_sfd_len,
    input  logic [7:0]       cfg_pre_pat,
    input  logic [7:0]       cfg_sfd_pat,
    input  logic             dio_in,
    output logic             dio_out,
    output logic             dio_oe,
    output logic             dclk,
    output logic             sym_out,
    input  logic             sym_in,
    output logic             rx_code_err
);
    localparam int FW = $clog2(8 * ((PRE_MAX > SFD_MAX) ? PRE_MAX : SFD_MAX) + 1);

    logic          active, start, manch, bit_end;
    logic          samp_mid, samp_a, samp_b, second_half;
    logic          dir_l, msb_l;
    logic [FW-1:0] pre_bits_l, sfd_bits_l;
    logic [7:0]    pre_pat_l, sfd_pat_l;
    logic [LEN_W-1:0] pre_cl, sfd_cl;
    logic          tx_on, rx_on;

    // Length clamping to the field maxima
    always_comb begin
        pre_cl = (cfg_pre_len > LEN_W'(PRE_MAX)) ? LEN_W'(PRE_MAX) : cfg_pre_len;
        sfd_cl = (cfg_sfd_len > LEN_W'(SFD_MAX)) ? LEN_W'(SFD_MAX) : cfg_sfd_len;
    end

    // Configuration capture at session start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_l      <= 1'b0;
            msb_l      <= 1'b0;
            pre_bits_l <= '0;
            sfd_bits_l <= '0;
            pre_pat_l  <= 8'h00;
            sfd_pat_l  <= 8'h00;
        end else if (start) begin
            dir_l      <= cfg_dir_tx;
            msb_l      <= cfg_msb_first;
            pre_bits_l <= FW'(pre_cl) << 3;
            sfd_bits_l <= FW'(sfd_cl) << 3;
            pre_pat_l  <= cfg_pre_pat;
            sfd_pat_l  <= cfg_sfd_pat;
        end
    end

    assign tx_on  = active && dir_l;
    assign rx_on  = active && !dir_l;
    assign dio_oe = rx_on;
    assign dclk   = second_half;

    bbs_bit_timer #(.BASE_DIV(BASE_DIV)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .manch_in    (cfg_manch),
        .rate_in     (cfg_rate),
        .active      (active),
        .start       (start),
        .manch       (manch),
        .bit_end     (bit_end),
        .samp_mid    (samp_mid),
        .samp_a      (samp_a),
        .samp_b      (samp_b),
        .second_half (second_half)
    );

    bbs_tx_engine #(.FW(FW)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .tx_on       (tx_on),
        .bit_end     (bit_end),
        .samp_mid    (samp_mid),
        .second_half (second_half),
        .manch       (manch),
        .msb_first   (msb_l),
        .pre_bits    (pre_bits_l),
        .sfd_bits    (sfd_bits_l),
        .pre_pat     (pre_pat_l),
        .sfd_pat     (sfd_pat_l),
        .dio_in      (dio_in),
        .sym_out     (sym_out)
    );

    bbs_rx_engine u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rx_on    (rx_on),
        .bit_end  (bit_end),
        .samp_a   (samp_a),
        .samp_b   (samp_b),
        .manch    (manch),
        .sym_in   (sym_in),
        .dio_out  (dio_out),
        .code_err (rx_code_err)
    );

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!dclk && !sym_out && !dio_oe));

    // R9
    turn_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dio_oe) |-> !dio_out);

    // R11
    dir_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_end) |=> $stable(dio_oe));

endmodule

// File: tb/tb_bbs_serdes_top.sv
module tb_bbs_serdes_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;

    typedef struct packed {
        logic        dir;
        logic        manch;
        logic [1:0]  rate;
        logic        msb;
        logic [4:0]  pre;
        logic [4:0]  sfd;
        logic [7:0]  ppat;
        logic [7:0]  spat;
        logic [15:0] data;
        logic [15:0] err;
        logic        poke;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 2'd2, 1'b1, 5'd1,  5'd1,  8'hA5, 8'h3C, 16'hB2E1, 16'h0000, 1'b0},
        '{1'b1, 1'b1, 2'd2, 1'b0, 5'd2,  5'd1,  8'h55, 8'hD3, 16'h0F96, 16'h0000, 1'b0},
        '{1'b1, 1'b0, 2'd1, 1'b0, 5'd0,  5'd2,  8'h00, 8'h9A, 16'h1234, 16'h0000, 1'b0},
        '{1'b1, 1'b1, 2'd0, 1'b1, 5'd0,  5'd0,  8'h00, 8'h00, 16'hCAFE, 16'h0000, 1'b0},
        '{1'b1, 1'b0, 2'd3, 1'b1, 5'd3,  5'd0,  8'hF0, 8'h00, 16'h8001, 16'h0000, 1'b1},
        '{1'b1, 1'b1, 2'd2, 1'b1, 5'd16, 5'd18, 8'h55, 8'h2D, 16'h00FF, 16'h0000, 1'b0},
        '{1'b1, 1'b0, 2'd2, 1'b0, 5'd20, 5'd25, 8'hC1, 8'h7E, 16'hA0A5, 16'h0000, 1'b0},
        '{1'b0, 1'b0, 2'd2, 1'b0, 5'd0,  5'd0,  8'h00, 8'h00, 16'hA5C3, 16'h0000, 1'b0},
        '{1'b0, 1'b1, 2'd2, 1'b0, 5'd0,  5'd0,  8'h00, 8'h00, 16'h6E19, 16'h0000, 1'b0},
        '{1'b0, 1'b1, 2'd1, 1'b0, 5'd0,  5'd0,  8'h00, 8'h00, 16'h3F01, 16'h0821, 1'b0},
        '{1'b0, 1'b0, 2'd0, 1'b0, 5'd0,  5'd0,  8'h00, 8'h00, 16'h5A5A, 16'h0000, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic cfg_dir_tx = 1'b0, cfg_manch = 1'b0, cfg_msb_first = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic [4:0] cfg_pre_len = '0, cfg_sfd_len = '0;
    logic [7:0] cfg_pre_pat = '0, cfg_sfd_pat = '0;
    logic dio_in = 1'b0, sym_in = 1'b0;
    logic dio_out, dio_oe, dclk, sym_out, rx_code_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bbs_serdes_top #(.BASE_DIV(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cfg_dir_tx(cfg_dir_tx), .cfg_manch(cfg_manch), .cfg_rate(cfg_rate),
        .cfg_msb_first(cfg_msb_first), .cfg_pre_len(cfg_pre_len),
        .cfg_sfd_len(cfg_sfd_len), .cfg_pre_pat(cfg_pre_pat),
        .cfg_sfd_pat(cfg_sfd_pat), .dio_in(dio_in), .dio_out(dio_out),
        .dio_oe(dio_oe), .dclk(dclk), .sym_out(sym_out), .sym_in(sym_in),
        .rx_code_err(rx_code_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sym_len(input logic [1:0] rate);
        case (rate)
            2'd0:    return BASE * 4;
            2'd1:    return BASE * 2;
            default: return BASE;
        endcase
    endfunction

    function automatic int clampi(input int v, input int mx);
        return (v > mx) ? mx : v;
    endfunction

    // Expected transmitted bit in period p (R3, R4, R5)
    function automatic logic tx_bit(input vec_t v, input int p);
        int np = clampi(v.pre, 16);
        int ns = clampi(v.sfd, 18);
        int k;
        if (p == 0) return 1'b0;
        k = p - 1;
        if (k < 8 * np) return v.msb ? v.ppat[7 - (k % 8)] : v.ppat[k % 8];
        k = k - 8 * np;
        if (k < 8 * ns) return v.msb ? v.spat[7 - (k % 8)] : v.spat[k % 8];
        k = k - 8 * ns;
        return (k < 16) ? v.data[k] : 1'b0;
    endfunction

    task automatic apply_cfg(input vec_t v);
        cfg_dir_tx    = v.dir;
        cfg_manch     = v.manch;
        cfg_rate      = v.rate;
        cfg_msb_first = v.msb;
        cfg_pre_len   = v.pre;
        cfg_sfd_len   = v.sfd;
        cfg_pre_pat   = v.ppat;
        cfg_sfd_pat   = v.spat;
    endtask

    task automatic poke_cfg(input vec_t v);
        cfg_dir_tx    = ~v.dir;
        cfg_manch     = ~v.manch;
        cfg_rate      = v.rate ^ 2'b10;
        cfg_msb_first = ~v.msb;
        cfg_pre_len   = 5'd0;
        cfg_sfd_len   = 5'd0;
        cfg_pre_pat   = ~v.ppat;
        cfg_sfd_pat   = ~v.spat;
    endtask

    task automatic run_tx(input vec_t v);
        int s  = sym_len(v.rate);
        int h  = v.manch ? 2 * s : s;
        int hd = 8 * (clampi(v.pre, 16) + clampi(v.sfd, 18));
        int np = 1 + hd + 16;
        @(negedge clk);
        apply_cfg(v);
        run = 1'b1;
        dio_in = 1'b0;
        @(posedge clk);
        for (int p = 0; p < np; p++) begin
            for (int c = 0; c < h; c++) begin
                logic b;
                logic es;
                @(negedge clk);
                if (c == 0) begin
                    int d = p - hd;
                    dio_in = (d >= 0 && d < 16) ? v.data[d] : 1'b0;
                end
                if (v.poke && p == 1 && c == 0) poke_cfg(v);
                b = tx_bit(v, p);
                if (c == 1 || c == h/2 + 1) begin
                    es = (p == 0) ? 1'b0 : (b ^ (v.manch && (c >= h/2)));
                    // R3 R4 R5 R6 (R11 when the vector pokes the configuration)
                    chk(v.poke ? "R11 sym_out" : "R6 sym_out", sym_out, es);
                    // R2
                    chk("R2 dclk", dclk, (c >= h/2));
                end
                if (c == 1) chk("R9 dio_oe in tx", dio_oe, 1'b0);
                if (p == np - 1 && c == h - 1) run = 1'b0;
            end
        end
        @(negedge clk);
        // R10
        chk("R10 idle dclk", dclk, 1'b0);
        chk("R10 idle sym_out", sym_out, 1'b0);
    endtask

    task automatic run_rx(input vec_t v);
        int s = sym_len(v.rate);
        int h = v.manch ? 2 * s : s;
        @(negedge clk);
        apply_cfg(v);
        run = 1'b1;
        sym_in = 1'b0;
        @(posedge clk);
        for (int p = 0; p < 17; p++) begin
            for (int c = 0; c < h; c++) begin
                logic b, f, sc;
                @(negedge clk);
                if (v.poke && p == 1 && c == 0) poke_cfg(v);
                if (p < 16) begin
                    b  = v.data[p];
                    f  = b;
                    sc = v.err[p] ? b : ~b;
                    sym_in = v.manch ? ((c < s) ? f : sc) : b;
                end else begin
                    sym_in = 1'b0;
                end
                if (c == 0) begin
                    // R8
                    chk("R8 err flag", rx_code_err,
                        (p > 0) && v.manch && v.err[p-1]);
                end
                if (c == 1) begin
                    // R7 R9
                    chk("R7 dio_out", dio_out, (p == 0) ? 1'b0 : v.data[p-1]);
                    chk(v.poke ? "R11 dio_oe" : "R9 dio_oe", dio_oe, 1'b1);
                    chk("R8 err pulse end", rx_code_err, 1'b0);
                end
                if (c == h/2 + 1) chk("R2 dclk rx", dclk, 1'b1);
                if (p == 16 && c == h - 1) run = 1'b0;
            end
        end
        @(negedge clk);
        // R9 R10
        chk("R9 dio_oe off", dio_oe, 1'b0);
        chk("R9 dio_out undriven", dio_out, 1'b0);
    endtask

    // Watchdog
    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk("R1 dclk", dclk, 1'b0);
        chk("R1 sym_out", sym_out, 1'b0);
        chk("R1 dio_oe", dio_oe, 1'b0);
        chk("R1 dio_out", dio_out, 1'b0);
        chk("R1 rx_code_err", rx_code_err, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].dir) run_tx(VECS[i]);
            else             run_rx(VECS[i]);
            repeat (3) @(negedge clk);
        end

        // R10: run dropped mid-period, session holds to the period end
        apply_cfg(VECS[0]);
        cfg_pre_len = 5'd0;
        cfg_sfd_len = 5'd0;
        run = 1'b1;
        @(posedge clk);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 still active dclk", dclk, 1'b1);
        @(negedge clk);
        chk("R10 still active dclk end", dclk, 1'b1);
        @(negedge clk);
        chk("R10 stopped dclk", dclk, 1'b0);
        repeat (BASE) @(negedge clk);
        chk("R10 stays idle", dclk, 1'b0);
        chk("R10 stays quiet", sym_out, 1'b0);

        // R1: reset in the middle of a receive session
        apply_cfg(VECS[7]);
        run = 1'b1;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        @(negedge clk);
        chk("R1 reset dio_oe", dio_oe, 1'b0);
        chk("R1 reset dclk", dclk, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule